// File: doc/BRIEF.md
# Multiplexed BCD Digit Capture

This block sits behind a dual-slope converter that presents its result one digit at a time. The converter raises one of five digit select lines, drives that digit's BCD code on a 4-bit bus, holds it for a fixed dwell, then moves on to the next lower digit. It repeats from the most significant digit after the least significant one. Alongside the digits it drives five status lines: strobe, busy, overrange, underrange and polarity.

All converter inputs pass through two-flop synchronizers. The block samples each digit a programmable number of cycles after its select line appears. It collects the five digits into a shadow register. It publishes a coherent five-digit reading with a one-cycle valid pulse only when a whole scan has been seen in the correct order. A run input set low freezes the published reading. Digits whose code is above 9 are flagged in a per-digit error vector.

Top module: `bcd_scan_capture`

## Requirements
- R1: `valid_o` rises exactly SAMPLE_DLY+4 clock cycles after the least significant digit select appears at the inputs of a scan that completes. All converter inputs pass through two synchronizer flops.
- R2: A digit is sampled SAMPLE_DLY cycles after its select line settles. A select held for fewer cycles than that is never sampled and has no effect on the scan.
- R3: A reading is published only after selects `dig_sel_i[4]`, `[3]`, `[2]`, `[1]`, `[0]` have each been sampled once, in that order. A sampled digit out of that order restarts the scan. If that digit is `dig_sel_i[4]`, it becomes the first digit of the new scan.
- R4: `reading_o[4k+3:4k]` holds the digit sampled under `dig_sel_i[k]`, so the most significant digit is in `[19:16]`. Bus bits 3..0 carry weights 8, 4, 2, 1.
- R5: `digit_err_o[k]` is set in a published reading when digit k is above 9.
- R6: `status_o` holds the status lines sampled with the least significant digit, packed as {strobe, busy, overrange, underrange, polarity} in bits 4..0.
- R7: While the synchronized run input is low, a completed scan publishes nothing: no valid pulse, and reading, status and flags are held. Once run is high again, the next completed scan publishes.
- R8: `valid_o` is high for one cycle per publication, never two cycles in a row.
- R9: After a synchronous active-low reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dig_sel_i | input | 5 | One-hot digit select; bit 4 is the most significant digit |
| bcd_i | input | 4 | BCD code of the selected digit |
| stat_strobe_i | input | 1 | Converter strobe status line |
| stat_busy_i | input | 1 | Converter busy line |
| stat_over_i | input | 1 | Overrange line |
| stat_under_i | input | 1 | Underrange line |
| stat_pol_i | input | 1 | Polarity line |
| run_i | input | 1 | High: publish readings; low: hold the last reading |
| reading_o | output | 20 | Published five-digit BCD reading |
| digit_err_o | output | 5 | Per-digit flag, set for a code above 9 |
| status_o | output | 5 | Published status {strobe, busy, over, under, pol} |
| valid_o | output | 1 | One-cycle pulse when a new reading is published |

## Verification
The bench builds the block with SAMPLE_DLY set to 4 and holds each digit for 10 cycles. This keeps a full scan to about 50 cycles, so many scans fit in a short run. It also lets a two-cycle select glitch fall well below the sample point, and it makes the exact publication cycle easy to predict. With these values the bench reaches broken orderings, restarts on the most significant digit, hold and resume through run, and codes above 9, each within a few scans.

// File: rtl/bcdcap_pkg.sv
// Package: shared sizes and the status record for the BCD digit capture block.
// Assumes a five-digit converter scan with a 4-bit BCD bus.
package bcdcap_pkg;
    localparam int NDIG   = 5;
    localparam int DIG_W  = 4;
    localparam int STAT_W = 5;
    localparam int IDX_W  = $clog2(NDIG);
    localparam int RD_W   = NDIG * DIG_W;

    // Status lines in published order, bit 4 down to bit 0.
    typedef struct packed {
        logic strb;
        logic busy;
        logic over;
        logic under;
        logic pol;
    } stat_t;
endpackage

// File: rtl/bcdcap_sync2.sv
// Module: two-flop synchronizer for a bundle of asynchronous converter lines.
// Assumes bundled lines settle well within one dwell, so skew between bits is harmless.
module bcdcap_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // Two-stage capture of the asynchronous bundle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/bcdcap_sampler.sv
// Module: detects a newly settled one-hot digit select and samples the bus once,
// SAMPLE_DLY cycles later, provided the select has stayed the same meanwhile.
// Assumes synchronized inputs and SAMPLE_DLY >= 1.
module bcdcap_sampler
    import bcdcap_pkg::*;
#(
    parameter int SAMPLE_DLY = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NDIG-1:0]  sel_i,
    input  logic [DIG_W-1:0] bcd_i,
    input  stat_t            stat_i,
    output logic             smp_v_o,
    output logic [IDX_W-1:0] smp_idx_o,
    output logic [DIG_W-1:0] smp_bcd_o,
    output stat_t            smp_stat_o
);
    localparam int CNT_W = $clog2(SAMPLE_DLY + 1);

    logic [NDIG-1:0]  prev_q, cur_q;
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic             is_new;
    logic [IDX_W-1:0] cur_idx;

    // A select counts as new when it is one-hot and differs from last cycle.
    always_comb is_new = $onehot(sel_i) && (sel_i != prev_q);

    // One-hot to index conversion of the armed select.
    always_comb begin
        cur_idx = '0;
        for (int i = 0; i < NDIG; i++)
            if (cur_q[i]) cur_idx = IDX_W'(i);
    end

    // Dwell counter: arm on a new select, sample once at the delay, disarm on change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q     <= '0;
            cur_q      <= '0;
            armed_q    <= 1'b0;
            cnt_q      <= '0;
            smp_v_o    <= 1'b0;
            smp_idx_o  <= '0;
            smp_bcd_o  <= '0;
            smp_stat_o <= '0;
        end else begin
            prev_q  <= sel_i;
            smp_v_o <= 1'b0;
            if (is_new) begin
                armed_q <= 1'b1;
                cnt_q   <= CNT_W'(1);
                cur_q   <= sel_i;
            end else if (armed_q) begin
                if (sel_i != cur_q) begin
                    armed_q <= 1'b0;
                end else if (cnt_q == CNT_W'(SAMPLE_DLY)) begin
                    smp_v_o    <= 1'b1;
                    smp_idx_o  <= cur_idx;
                    smp_bcd_o  <= bcd_i;
                    smp_stat_o <= stat_i;
                    armed_q    <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    // R2: each settled select produces at most one sample, never back to back.
    a_r2_single_sample: assert property (@(posedge clk) disable iff (!rst_n)
        smp_v_o |=> !smp_v_o);

    // R2: a sample always names a real digit position.
    a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        smp_v_o |-> (smp_idx_o < IDX_W'(NDIG)));
endmodule

// File: rtl/bcdcap_tracker.sv
// Module: checks the most-significant-first order of sampled digits, assembles
// them and publishes a full reading with flags and status when run is high.
// Assumes at most one sample per cycle from the sampler.
module bcdcap_tracker
    import bcdcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_v_i,
    input  logic [IDX_W-1:0] smp_idx_i,
    input  logic [DIG_W-1:0] smp_bcd_i,
    input  stat_t            smp_stat_i,
    input  logic             run_i,
    output logic [RD_W-1:0]  reading_o,
    output logic [NDIG-1:0]  digit_err_o,
    output stat_t            status_o,
    output logic             valid_o
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(NDIG - 1);

    logic [NDIG-1:0][DIG_W-1:0] shadow_q, full;
    logic [IDX_W-1:0]           exp_q;
    logic [NDIG-1:0]            full_err;

    // Complete reading as it would look with the current sample as the last digit.
    always_comb begin
        full    = shadow_q;
        full[0] = smp_bcd_i;
    end

    // One range comparator per digit position.
    for (genvar g = 0; g < NDIG; g++) begin : g_err
        assign full_err[g] = (full[g] > DIG_W'(9));
    end

    // Order tracking, shadow fill and gated publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q       <= TOP;
            shadow_q    <= '0;
            reading_o   <= '0;
            digit_err_o <= '0;
            status_o    <= '0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (smp_v_i) begin
                if (smp_idx_i == exp_q) begin
                    shadow_q[smp_idx_i] <= smp_bcd_i;
                    if (exp_q == '0) begin
                        exp_q <= TOP;
                        if (run_i) begin
                            reading_o   <= full;
                            digit_err_o <= full_err;
                            status_o    <= smp_stat_i;
                            valid_o     <= 1'b1;
                        end
                    end else begin
                        exp_q <= exp_q - IDX_W'(1);
                    end
                end else if (smp_idx_i == TOP) begin
                    shadow_q[TOP] <= smp_bcd_i;
                    exp_q         <= TOP - IDX_W'(1);
                end else begin
                    exp_q <= TOP;
                end
            end
        end
    end

    // R8: publication is a single-cycle pulse.
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R3: a publication always follows a sample of the least significant digit.
    a_r3_publish_after_d1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(smp_v_i) && ($past(smp_idx_i) == '0)));

    // R7: with run low the reading stays put and no pulse appears.
    a_r7_hold_reading: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> ($stable(reading_o) && !valid_o));

    // R5: published flags agree with the published digits.
    for (genvar k = 0; k < NDIG; k++) begin : g_err_chk
        a_r5_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
            digit_err_o[k] == (reading_o[k*DIG_W +: DIG_W] > DIG_W'(9)));
    end
endmodule

// File: rtl/bcd_scan_capture.sv
// Module: top of the multiplexed BCD digit capture. Synchronizes the converter
// lines, samples each digit mid-dwell and publishes complete ordered scans.
// Assumes select lines are one-hot while a digit is driven.
module bcd_scan_capture
    import bcdcap_pkg::*;
#(
    parameter int SAMPLE_DLY = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      dig_sel_i,
    input  logic [3:0]      bcd_i,
    input  logic            stat_strobe_i,
    input  logic            stat_busy_i,
    input  logic            stat_over_i,
    input  logic            stat_under_i,
    input  logic            stat_pol_i,
    input  logic            run_i,
    output logic [19:0]     reading_o,
    output logic [4:0]      digit_err_o,
    output logic [4:0]      status_o,
    output logic            valid_o
);
    localparam int SYNC_W = NDIG + DIG_W + STAT_W + 1;

    logic [SYNC_W-1:0] raw, synced;
    logic [NDIG-1:0]   sel_s;
    logic [DIG_W-1:0]  bcd_s;
    stat_t             stat_s, smp_stat, pub_stat;
    logic              run_s;
    logic              smp_v;
    logic [IDX_W-1:0]  smp_idx;
    logic [DIG_W-1:0]  smp_bcd;

    // Gather every converter line into one bundle for the synchronizer.
    always_comb raw = {dig_sel_i, bcd_i, stat_strobe_i, stat_busy_i,
                       stat_over_i, stat_under_i, stat_pol_i, run_i};

    bcdcap_sync2 #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (synced)
    );

    // Split the synchronized bundle back into its fields.
    always_comb {sel_s, bcd_s, stat_s, run_s} = synced;

    bcdcap_sampler #(.SAMPLE_DLY(SAMPLE_DLY)) u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel_s),
        .bcd_i      (bcd_s),
        .stat_i     (stat_s),
        .smp_v_o    (smp_v),
        .smp_idx_o  (smp_idx),
        .smp_bcd_o  (smp_bcd),
        .smp_stat_o (smp_stat)
    );

    bcdcap_tracker u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_v_i     (smp_v),
        .smp_idx_i   (smp_idx),
        .smp_bcd_i   (smp_bcd),
        .smp_stat_i  (smp_stat),
        .run_i       (run_s),
        .reading_o   (reading_o),
        .digit_err_o (digit_err_o),
        .status_o    (pub_stat),
        .valid_o     (valid_o)
    );

    // Present the status record as a flat vector.
    always_comb status_o = pub_stat;
endmodule

// File: tb/sim_bcd_scan_capture.sv
// Bench: drives a behavioural converter scan and compares the outputs with a
// queue-based reference model on every clock.
module sim_bcd_scan_capture;
    localparam int DLY   = 4;
    localparam int DWELL = 10;
    localparam int LAT   = DLY + 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  dig_sel_i = '0;
    logic [3:0]  bcd_i = '0;
    logic        stat_strobe_i = 0, stat_busy_i = 0, stat_over_i = 0;
    logic        stat_under_i = 0, stat_pol_i = 0;
    logic        run_i = 1'b1;
    logic [19:0] reading_o;
    logic [4:0]  digit_err_o, status_o;
    logic        valid_o;

    always #10 clk = ~clk;

    bcd_scan_capture #(.SAMPLE_DLY(DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .dig_sel_i(dig_sel_i), .bcd_i(bcd_i),
        .stat_strobe_i(stat_strobe_i), .stat_busy_i(stat_busy_i),
        .stat_over_i(stat_over_i), .stat_under_i(stat_under_i),
        .stat_pol_i(stat_pol_i), .run_i(run_i), .reading_o(reading_o),
        .digit_err_o(digit_err_o), .status_o(status_o), .valid_o(valid_o)
    );

    typedef struct {
        int         cyc;
        logic [19:0] rd;
        logic [4:0]  st;
        logic [4:0]  er;
    } ev_t;

    ev_t         evq[$];
    int          cyc = 0;
    int          n_chk = 0, n_fail = 0;
    int          vcount = 0;
    logic        prev_valid = 1'b0;
    logic        mon_en = 1'b0;
    logic        done = 1'b0;
    logic [19:0] m_rd = '0;
    logic [4:0]  m_st = '0, m_er = '0;
    int          exp_ptr = 4;
    logic [3:0]  sh[5];
    logic        run_m = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Per-clock comparison against the reference model.
    always @(negedge clk) begin
        if (rst_n && mon_en) begin : mon
            bit hit;
            hit = (evq.size() > 0) && (evq[0].cyc == cyc);
            if (hit) begin
                m_rd = evq[0].rd;
                m_st = evq[0].st;
                m_er = evq[0].er;
                void'(evq.pop_front());
            end
            chk(valid_o == hit, "R1", "valid timing", {31'd0, valid_o}, {31'd0, hit});
            chk(reading_o == m_rd, "R4", "reading", {12'd0, reading_o}, {12'd0, m_rd});
            chk(status_o == m_st, "R6", "status", {27'd0, status_o}, {27'd0, m_st});
            chk(digit_err_o == m_er, "R5", "digit flags", {27'd0, digit_err_o}, {27'd0, m_er});
            chk(!(valid_o && prev_valid), "R8", "pulse width", {31'd0, valid_o}, 32'd0);
            if (valid_o) vcount++;
            prev_valid = valid_o;
        end
    end

    // Drive one digit for a number of cycles and advance the model.
    task automatic put_digit(input int idx, input logic [3:0] v,
                             input logic [4:0] st, input int dwell);
        int start;
        @(negedge clk);
        dig_sel_i = 5'b00001 << idx;
        bcd_i = v;
        {stat_strobe_i, stat_busy_i, stat_over_i, stat_under_i, stat_pol_i} = st;
        start = cyc;
        if (dwell >= DLY + 3) begin
            if (idx == exp_ptr) begin
                sh[idx] = v;
                if (idx == 0) begin
                    exp_ptr = 4;
                    if (run_m) begin : pub
                        ev_t e;
                        e.cyc = start + LAT;
                        e.rd  = {sh[4], sh[3], sh[2], sh[1], sh[0]};
                        e.st  = st;
                        for (int k = 0; k < 5; k++) e.er[k] = (sh[k] > 4'd9);
                        evq.push_back(e);
                    end
                end else begin
                    exp_ptr = exp_ptr - 1;
                end
            end else if (idx == 4) begin
                sh[4] = v;
                exp_ptr = 3;
            end else begin
                exp_ptr = 4;
            end
        end
        repeat (dwell - 1) @(negedge clk);
    endtask

    task automatic scan(input logic [19:0] val, input logic [4:0] st);
        for (int i = 4; i >= 0; i--) put_digit(i, val[i*4 +: 4], st, DWELL);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        dig_sel_i = '0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic set_run(input logic b);
        @(negedge clk);
        run_i = b;
        run_m = b;
        repeat (6) @(negedge clk);
    endtask

    // Watchdog: an overlong run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v0;
        for (int k = 0; k < 5; k++) sh[k] = '0;
        repeat (3) @(negedge clk);
        chk(reading_o == '0 && valid_o == 1'b0 && status_o == '0 && digit_err_o == '0,
            "R9", "outputs in reset", {12'd0, reading_o}, 32'd0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        chk(reading_o == '0 && valid_o == 1'b0, "R9", "outputs after reset",
            {12'd0, reading_o}, 32'd0);
        idle(5);

        // R4 / R6: plain ordered scan.
        v0 = vcount;
        scan(20'h12345, 5'b10101);
        idle(6);
        chk(reading_o == 20'h12345, "R4", "first scan", {12'd0, reading_o}, 32'h12345);
        chk(status_o == 5'b10101, "R6", "first status", {27'd0, status_o}, 32'h15);
        chk(vcount == v0 + 1, "R8", "one pulse per scan", vcount, v0 + 1);

        // R4 / R6: different digits and status, back-to-back scans.
        scan(20'h90701, 5'b01010);
        scan(20'h55555, 5'b00001);
        idle(6);
        chk(reading_o == 20'h55555, "R4", "back-to-back", {12'd0, reading_o}, 32'h55555);
        chk(status_o == 5'b00001, "R6", "polarity only", {27'd0, status_o}, 32'h1);

        // R5: codes above 9.
        scan(20'hAF09B, 5'b00000);
        idle(6);
        chk(digit_err_o == 5'b11001, "R5", "error flags", {27'd0, digit_err_o}, 32'h19);

        // R3: broken order gives no reading.
        v0 = vcount;
        put_digit(4, 4'd1, 5'b0, DWELL);
        put_digit(3, 4'd2, 5'b0, DWELL);
        put_digit(1, 4'd3, 5'b0, DWELL);
        put_digit(0, 4'd4, 5'b0, DWELL);
        idle(12);
        chk(vcount == v0, "R3", "skipped digit not published", vcount, v0);
        chk(reading_o == 20'hAF09B, "R3", "reading kept", {12'd0, reading_o}, 32'hAF09B);

        // R3: a repeated top digit restarts the scan.
        put_digit(4, 4'd6, 5'b0, DWELL);
        put_digit(3, 4'd7, 5'b0, DWELL);
        scan(20'h89012, 5'b00100);
        idle(6);
        chk(reading_o == 20'h89012, "R3", "restart on top digit", {12'd0, reading_o}, 32'h89012);

        // R2: a short select glitch is ignored.
        put_digit(4, 4'd3, 5'b0, DWELL);
        put_digit(3, 4'd4, 5'b0, DWELL);
        put_digit(0, 4'd9, 5'b0, 2);
        put_digit(2, 4'd5, 5'b0, DWELL);
        put_digit(1, 4'd6, 5'b0, DWELL);
        put_digit(0, 4'd7, 5'b11000, DWELL);
        idle(6);
        chk(reading_o == 20'h34567, "R2", "glitch ignored", {12'd0, reading_o}, 32'h34567);

        // R7: hold with run low, resume with run high.
        set_run(1'b0);
        v0 = vcount;
        scan(20'h24680, 5'b11111);
        idle(6);
        chk(vcount == v0, "R7", "no pulse while held", vcount, v0);
        chk(reading_o == 20'h34567, "R7", "reading held", {12'd0, reading_o}, 32'h34567);
        chk(status_o == 5'b11000, "R7", "status held", {27'd0, status_o}, 32'h18);
        set_run(1'b1);
        scan(20'h13579, 5'b00010);
        idle(6);
        chk(vcount == v0 + 1, "R7", "resumed pulse", vcount, v0 + 1);
        chk(reading_o == 20'h13579, "R7", "resumed reading", {12'd0, reading_o}, 32'h13579);

        // R1: every scheduled publication has been consumed.
        chk(evq.size() == 0, "R1", "all publications seen", evq.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule